// File: doc/BRIEF.md
# Repeating ADC Conversion Sequencer

This block runs a successive-approximation analog-to-digital converter in single-channel mode. A host writes two registers over a simple write-only bus: a mode register, whose bit 7 enables conversion, and a channel register that selects one of eight analog inputs. While enabled, the sequencer drives the analog multiplexer select and a 10-bit trial code toward an external comparator. It reads back one decision bit per cycle and builds the result. When a conversion completes, the result is latched and a one-cycle interrupt is raised. The next conversion starts on the following cycle with no host action.

Writing the channel register while enabled throws away the partial conversion and starts again on the new channel. Writing 0 to the enable bit halts the sequencer at once. In both cases the result register keeps the last completed value. The result can be read as a left-justified 16-bit word or as an 8-bit view of its upper bits.

Top module: `adc_seq_ctrl`

## Requirements
- R1: `mux_sel` always equals bits [2:0] of the most recent write to the channel register (`bus_addr`=1), whether or not conversion is enabled. A channel write while disabled starts nothing.
- R2: A write to the mode register (`bus_addr`=0) with `bus_wdata[7]`=1 while idle starts conversion. The first interrupt is visible 19 cycles after the clock edge that takes the write.
- R3: At each completion the result register is updated, and `conv_irq` is high for exactly one cycle, in the same cycle the new result first appears.
- R4: While enabled, conversions repeat without host action. Interrupts follow one another every 18 cycles.
- R5: A channel write while enabled aborts the current conversion and restarts on the new channel. The next interrupt comes 18 cycles after the write edge and carries the new channel's value.
- R6: A mode write with `bus_wdata[7]`=0 stops the sequencer at once. No further interrupt occurs, and `trial_code` returns to 0.
- R7: An aborted or stopped conversion leaves the result register holding the last completed value.
- R8: `result_word` equals the 10-bit result shifted left by 6. `result_hi` equals result bits [9:2].
- R9: Each conversion is 8 sampling cycles followed by 10 trials, MSB first. A trial bit is kept when `cmp_ge`=1 (input at or above `trial_code`). With an ideal comparator, the result equals the input code.
- R10: A mode write with `bus_wdata[7]`=1 while already converting does not disturb the conversion or its timing.
- R11: After reset the enable is off, the channel is 0, the result is 0, `trial_code` is 0 and `conv_irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one cycle |
| bus_addr | input | 1 | 0 selects the mode register, 1 selects the channel register |
| bus_wdata | input | 8 | Write data |
| cmp_ge | input | 1 | Comparator decision: input at or above the trial code |
| mux_sel | output | 3 | Analog channel select |
| trial_code | output | 10 | Successive-approximation trial code for the comparator |
| result_word | output | 16 | Left-justified result |
| result_hi | output | 8 | Upper 8 result bits |
| conv_irq | output | 1 | One-cycle completion pulse |

## Verification
The bench numbers every clock edge. A register write belongs to the edge that samples it. The first result of an enable is due 19 edges after that write, each repeated result 18 edges after the one before, and a restarted result 18 edges after the channel write. The driver logs the edge of each write and queues the result cycle and value that the requirements predict, using an ideal comparator model. The monitor samples on falling edges and compares each interrupt against the head of the queue, both its cycle number and its value. Any interrupt with no queued entry fails, so a stop or an abort that lets a completion slip through is caught.

// File: rtl/adc_seq_pkg.sv
// Shared definitions for the conversion sequencer.
// Assumes a single write port with a one-bit register address.
package adc_seq_pkg;
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SAMPLE = 2'd1,
        PH_CONV   = 2'd2
    } phase_t;

    localparam logic ADDR_MODE = 1'b0;
    localparam logic ADDR_CHAN = 1'b1;
    localparam int   EN_BIT    = 7;
endpackage

// File: rtl/adc_seq_regs.sv
// Host-visible mode and channel registers.
// Decodes writes into a stop request (enable cleared) and a restart
// request (channel written). Assumes at most one write per cycle.
module adc_seq_regs
    import adc_seq_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CH_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic              addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              en_o,
    output logic [CH_W-1:0]   chan_o,
    output logic              stop_o,
    output logic              restart_o
);
    logic            en_q;
    logic [CH_W-1:0] chan_q;
    logic            wr_mode;
    logic            wr_chan;
    logic            unused_wbits;

    // Decode which register the current write targets.
    always_comb begin
        wr_mode = wr_i && (addr_i == ADDR_MODE);
        wr_chan = wr_i && (addr_i == ADDR_CHAN);
    end

    assign unused_wbits = ^wdata_i;

    // Hold the enable bit and the channel number.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            chan_q <= '0;
        end else begin
            if (wr_mode) en_q   <= wdata_i[EN_BIT];
            if (wr_chan) chan_q <= wdata_i[CH_W-1:0];
        end
    end

    assign en_o      = en_q;
    assign chan_o    = chan_q;
    assign stop_o    = wr_mode && !wdata_i[EN_BIT];
    assign restart_o = wr_chan;
endmodule

// File: rtl/adc_seq_sar.sv
// Phase controller and successive-approximation register.
// Samples for SAMPLE_CYC cycles, then runs RES_W trials MSB first, one
// comparator decision per cycle. Stop overrides restart, and restart
// overrides normal stepping. Assumes cmp_ge_i answers the current trial
// code within the same cycle.
module adc_seq_sar
    import adc_seq_pkg::*;
#(
    parameter int RES_W      = 10,
    parameter int SAMPLE_CYC = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             stop_i,
    input  logic             restart_i,
    input  logic             cmp_ge_i,
    output logic [RES_W-1:0] trial_o,
    output logic             done_o,
    output logic [RES_W-1:0] res_o
);
    localparam int MAXC  = (SAMPLE_CYC > RES_W) ? SAMPLE_CYC : RES_W;
    localparam int CNT_W = (MAXC > 1) ? $clog2(MAXC) : 1;

    phase_t           ph_q;
    logic [CNT_W-1:0] cnt_q;
    logic [RES_W-1:0] sar_q;
    logic [RES_W-1:0] sar_upd;
    logic             go_restart;

    assign go_restart = restart_i && en_i;

    // Trial code and register update, one bit slice per result bit.
    for (genvar i = 0; i < RES_W; i++) begin : g_bit
        logic at_bit;
        assign at_bit     = (cnt_q == CNT_W'(i));
        assign trial_o[i] = (ph_q == PH_CONV) && (sar_q[i] || at_bit);
        assign sar_upd[i] = at_bit ? cmp_ge_i : sar_q[i];
    end

    // Completion of the last trial, unless aborted in the same cycle.
    always_comb begin
        done_o = (ph_q == PH_CONV) && (cnt_q == '0) && !stop_i && !go_restart;
        res_o  = sar_upd;
    end

    // Phase sequencing with abort and automatic restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q  <= PH_IDLE;
            cnt_q <= '0;
            sar_q <= '0;
        end else if (stop_i) begin
            ph_q  <= PH_IDLE;
            cnt_q <= '0;
            sar_q <= '0;
        end else if (go_restart) begin
            ph_q  <= PH_SAMPLE;
            cnt_q <= '0;
            sar_q <= '0;
        end else begin
            case (ph_q)
                PH_IDLE: begin
                    if (en_i) begin
                        ph_q  <= PH_SAMPLE;
                        cnt_q <= '0;
                    end
                end
                PH_SAMPLE: begin
                    if (cnt_q == CNT_W'(SAMPLE_CYC - 1)) begin
                        ph_q  <= PH_CONV;
                        cnt_q <= CNT_W'(RES_W - 1);
                        sar_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PH_CONV: begin
                    if (cnt_q == '0) begin
                        ph_q  <= PH_SAMPLE;
                        sar_q <= '0;
                    end else begin
                        sar_q <= sar_upd;
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: ph_q <= PH_IDLE;
            endcase
        end
    end

    AST_STOP_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> (ph_q == PH_IDLE && trial_o == '0)); // R6
    AST_RESTART_SAMPLES: assert property (@(posedge clk) disable iff (!rst_n)
        (go_restart && !stop_i) |=> (ph_q == PH_SAMPLE && cnt_q == '0)); // R5
    AST_DONE_REPEATS: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (ph_q == PH_SAMPLE && cnt_q == '0)); // R4
    AST_MSB_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_SAMPLE && cnt_q == CNT_W'(SAMPLE_CYC - 1) && !stop_i && !go_restart)
        |=> (trial_o == (RES_W'(1) << (RES_W - 1)))); // R9
endmodule

// File: rtl/adc_seq_result.sv
// Result register with its two read views and the completion pulse.
// Assumes done_i is a single-cycle strobe from the phase controller.
module adc_seq_result #(
    parameter int RES_W  = 10,
    parameter int WORD_W = 16,
    parameter int HI_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done_i,
    input  logic [RES_W-1:0]  res_i,
    output logic [WORD_W-1:0] word_o,
    output logic [HI_W-1:0]   hi_o,
    output logic              irq_o
);
    localparam int PAD_W = WORD_W - RES_W;

    logic [RES_W-1:0] res_q;
    logic             irq_q;

    // Latch a completed result and raise the interrupt with it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
            irq_q <= 1'b0;
        end else begin
            irq_q <= done_i;
            if (done_i) res_q <= res_i;
        end
    end

    assign word_o = {res_q, {PAD_W{1'b0}}};
    assign hi_o   = res_q[RES_W-1 -: HI_W];
    assign irq_o  = irq_q;

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |=> !irq_q); // R3
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !done_i |=> $stable(res_q)); // R7
endmodule

// File: rtl/adc_seq_ctrl.sv
// Top of the repeating conversion sequencer: register file, phase and
// approximation controller, result register. Assumes an external
// comparator that answers within one cycle.
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int CH_W       = 3,
    parameter int RES_W      = 10,
    parameter int SAMPLE_CYC = 8,
    parameter int WORD_W     = 16,
    parameter int HI_W       = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              cmp_ge,
    output logic [CH_W-1:0]   mux_sel,
    output logic [RES_W-1:0]  trial_code,
    output logic [WORD_W-1:0] result_word,
    output logic [HI_W-1:0]   result_hi,
    output logic              conv_irq
);
    logic             en;
    logic             stop_req;
    logic             restart_req;
    logic             done;
    logic [RES_W-1:0] res_val;

    adc_seq_regs #(.DATA_W(DATA_W), .CH_W(CH_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (bus_wr),
        .addr_i    (bus_addr),
        .wdata_i   (bus_wdata),
        .en_o      (en),
        .chan_o    (mux_sel),
        .stop_o    (stop_req),
        .restart_o (restart_req)
    );

    adc_seq_sar #(.RES_W(RES_W), .SAMPLE_CYC(SAMPLE_CYC)) u_sar (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (en),
        .stop_i    (stop_req),
        .restart_i (restart_req),
        .cmp_ge_i  (cmp_ge),
        .trial_o   (trial_code),
        .done_o    (done),
        .res_o     (res_val)
    );

    adc_seq_result #(.RES_W(RES_W), .WORD_W(WORD_W), .HI_W(HI_W)) u_res (
        .clk    (clk),
        .rst_n  (rst_n),
        .done_i (done),
        .res_i  (res_val),
        .word_o (result_word),
        .hi_o   (result_hi),
        .irq_o  (conv_irq)
    );

    AST_CHAN_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == ADDR_CHAN) |=> $stable(mux_sel)); // R1
    AST_NO_IRQ_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_MODE && !bus_wdata[EN_BIT]) |=> ##1 !conv_irq); // R6
endmodule

// File: tb/adc_seq_ctrl_test.sv
// Scoreboard bench: the driver queues predicted interrupt cycles and
// values, and the monitor pops and compares them on falling edges.
module adc_seq_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_addr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic       cmp_ge;
    logic [2:0] mux_sel;
    logic [9:0] trial_code;
    logic [15:0] result_word;
    logic [7:0] result_hi;
    logic       conv_irq;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int last_wr = 0;
    bit irq_prev = 1'b0;
    int unsigned exp_cyc[$];
    logic [9:0]  exp_val[$];
    logic [9:0]  vin [8];
    logic [9:0]  last_res = '0;

    always #10 clk = ~clk;   // 50 MHz

    adc_seq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .cmp_ge(cmp_ge), .mux_sel(mux_sel),
        .trial_code(trial_code), .result_word(result_word),
        .result_hi(result_hi), .conv_irq(conv_irq)
    );

    // Ideal comparator model (R9).
    assign cmp_ge = (vin[mux_sel] >= trial_code);

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        last_wr = cyc;
    endtask

    task automatic expect_irq(input int c, input logic [9:0] v);
        exp_cyc.push_back(c);
        exp_val.push_back(v);
    endtask

    task automatic wait_to(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    // Monitor: compare each interrupt against the queue head.
    always @(negedge clk) begin
        if (rst_n) begin
            if (conv_irq && irq_prev)
                check(1'b0, "R3 pulse width", 2, 1);
            if (conv_irq) begin
                if (exp_cyc.size() == 0) begin
                    check(1'b0, "R6/R7 unexpected irq", cyc, 0);
                end else begin
                    int unsigned ec;
                    logic [9:0] ev;
                    ec = exp_cyc.pop_front();
                    ev = exp_val.pop_front();
                    check(cyc == int'(ec), "R2/R4/R5 irq cycle", cyc, int'(ec));
                    check(result_word == {ev, 6'b0}, "R3/R9 result value",
                          int'(result_word[15:6]), int'(ev));
                    check(result_hi == ev[9:2], "R8 high view",
                          int'(result_hi), int'(ev[9:2]));
                    last_res = ev;
                end
            end
            irq_prev = conv_irq;
        end
    end

    initial begin : watchdog
        wait_to(60000);
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        int s;
        vin[0] = 10'd0;   vin[1] = 10'd1023; vin[2] = 10'd512; vin[3] = 10'd511;
        vin[4] = 10'd341; vin[5] = 10'd682;  vin[6] = 10'd1;   vin[7] = 10'd1000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check(mux_sel == 3'd0, "R11 channel", int'(mux_sel), 0);
        check(trial_code == '0, "R11 trial", int'(trial_code), 0);
        check(result_word == '0, "R11 result", int'(result_word), 0);
        check(!conv_irq, "R11 irq", int'(conv_irq), 0);

        // R1: channel write while disabled starts nothing
        wr(1'b1, 8'h03);
        check(mux_sel == 3'd3, "R1 select", int'(mux_sel), 3);
        wait_to(last_wr + 30);
        check(trial_code == '0, "R1 idle trial", int'(trial_code), 0);

        // R2/R4: enable and let it repeat
        wr(1'b0, 8'h80);
        s = last_wr;
        expect_irq(s + 19, vin[3]);
        expect_irq(s + 37, vin[3]);
        expect_irq(s + 55, vin[3]);
        expect_irq(s + 73, vin[3]);
        // R10: enable rewritten mid-conversion, timing unchanged
        wait_to(s + 60);
        wr(1'b0, 8'h81);
        wait_to(s + 74);
        check(exp_cyc.size() == 0, "R10 queue drained", exp_cyc.size(), 0);

        // R5: channel write mid-conversion restarts on new channel
        wait_to(s + 80);
        wr(1'b1, 8'h05);
        s = last_wr;
        expect_irq(s + 18, vin[5]);
        expect_irq(s + 36, vin[5]);
        wait_to(s + 37);

        // R5/R9: sweep every channel, each write aborting the next run
        for (int ch = 0; ch < 8; ch++) begin
            wr(1'b1, 8'(ch));
            s = last_wr;
            check(mux_sel == 3'(ch), "R1 select sweep", int'(mux_sel), ch);
            expect_irq(s + 18, vin[ch]);
            wait_to(s + 19);
            wait_to(s + 28);
        end
        check(exp_cyc.size() == 0, "R5 sweep drained", exp_cyc.size(), 0);

        // R6/R7: stop mid-conversion; no irq, result held
        wr(1'b0, 8'h00);
        @(negedge clk);
        check(trial_code == '0, "R6 trial cleared", int'(trial_code), 0);
        wait_to(last_wr + 60);
        check(result_word[15:6] == vin[7], "R7 result held",
              int'(result_word[15:6]), int'(vin[7]));
        check(result_hi == vin[7][9:2], "R8 held view", int'(result_hi), int'(vin[7][9:2]));

        // R2/R7: restart, then stop during sampling of the repeat
        wr(1'b1, 8'h02);
        wr(1'b0, 8'h80);
        s = last_wr;
        expect_irq(s + 19, vin[2]);
        wait_to(s + 23);
        wr(1'b0, 8'h00);
        wait_to(last_wr + 40);
        check(result_word[15:6] == vin[2], "R7 held after stop",
              int'(result_word[15:6]), int'(vin[2]));
        check(exp_cyc.size() == 0, "R6 no pending", exp_cyc.size(), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule